// File: doc/BRIEF.md
# Replica Way Selector for a Shared Cache Slice

When a line leaves a tile's first-level cache because of a capacity eviction, this block decides whether a copy of that line is kept in the tile's own slice of the shared second-level cache, and in which way of the target set the copy goes. The request brings the set index, the line tag and the per-way state of the 16-way set. Each way is invalid, a home line (with or without sharers), or a replica. The block then answers with a way choice, or with a decision not to replicate.

The victim class has a strict priority. A replica of the same tag that is already in the set is reused first. After that come an invalid way, then a home line with no sharers, then any existing replica. A home line that still has sharers is never displaced. Inside the winning class the way is chosen pseudo-randomly. A rotating find-first search starts at a point taken from an LFSR. The decision is registered one cycle after the request is accepted, which fits well inside the slice's six-cycle lookup. When the response is taken, a single-cycle write command installs the line as a replica. An extra flag tells the directory that a sharer-free home line was dropped.

Top module: `vr_way_select`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o is 0 and wr_en_o is 0.
- R2: A request is accepted on a clock edge where req_valid_i and req_ready_o are both 1. rsp_valid_o is 1 from the next cycle. req_ready_o stays 0 and every response field stays stable until the edge where rsp_ready_i is 1. After that edge rsp_valid_o is 0 and req_ready_o is 1.
- R3: Reuse has top priority. If some way is valid, marks a replica (way_repl_i bit set) and has a tag (way i at way_tags_i[i*TAG_W +: TAG_W]) equal to req_tag_i, the lowest such way is returned with replicated 1 and evicted_home 0.
- R4: Otherwise, if any way is invalid (way_valid_i bit 0), an invalid way is chosen and evicted_home is 0.
- R5: Otherwise, if any way is a valid home line without sharers (valid 1, way_repl_i 0, way_shrd_i 0), that way class is chosen and rsp_evict_home_o is 1.
- R6: Otherwise, if any way is a valid replica, a replica way is chosen and evicted_home is 0.
- R7: A valid home line with sharers (valid 1, way_repl_i 0, way_shrd_i 1) is never chosen. If no other class exists, the response has replicated 0, way 0 and evicted_home 0, and no write is issued.
- R8: In R4 to R6 the way is the first candidate found when searching upward modulo 16 from a start index. The start index is the low 4 bits of a 16-bit Galois LFSR value, taken at the accept edge. The LFSR resets to 16'hACE1. It steps once per accepted request: shift right one bit, and if the bit shifted out was 1, XOR with 16'hB400.
- R9: wr_en_o is 1 only in the cycle where a replicated response is taken (rsp_valid_o and rsp_ready_i both 1). In that cycle wr_set_o and wr_tag_o carry the request's set and tag.
- R10: The way state, tag and set are captured at acceptance. Input changes while the request is in flight have no effect on the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Eviction request valid |
| req_ready_o | output | 1 | Block idle, can take a request |
| req_set_i | input | SET_W | Target set index |
| req_tag_i | input | TAG_W | Tag of the evicted line |
| way_valid_i | input | NUM_WAYS | Per-way valid |
| way_repl_i | input | NUM_WAYS | Per-way replica marker |
| way_shrd_i | input | NUM_WAYS | Per-way home line has one or more sharers |
| way_tags_i | input | NUM_WAYS*TAG_W | Per-way tags, way i at bits i*TAG_W |
| rsp_valid_o | output | 1 | Decision valid |
| rsp_ready_i | input | 1 | Decision taken |
| rsp_replicated_o | output | 1 | A replica is written |
| rsp_way_o | output | WAY_W | Chosen way |
| rsp_evict_home_o | output | 1 | A sharer-free home line is displaced |
| wr_en_o | output | 1 | One-cycle replica install command |
| wr_set_o | output | SET_W | Set of the install |
| wr_tag_o | output | TAG_W | Tag of the install |

## Verification
The assertions assume a consistent state vector: a replica bit or a sharer bit on an invalid way does not matter, and at most one valid replica carries any given tag. They also assume the consumer may hold rsp_ready_i low for any number of cycles. The stimulus keeps to this. Every way has a distinct tag, matching requests name exactly one replica, and each response is deliberately held for a cycle before it is taken. During that held cycle the way inputs are scrambled to test capture.

// File: rtl/vr_pkg.sv
package vr_pkg;
  typedef enum logic [2:0] {
    CLS_NONE  = 3'd0,
    CLS_MATCH = 3'd1,
    CLS_INV   = 3'd2,
    CLS_FREE  = 3'd3,
    CLS_REP   = 3'd4
  } vr_cls_e;

  localparam int unsigned NUM_CLS = 4;  // match, invalid, free home, replica
endpackage

// File: rtl/vr_lfsr.sv
module vr_lfsr #(
  parameter int unsigned           W    = 16,
  parameter logic [W-1:0]          SEED = 16'hACE1,
  parameter logic [W-1:0]          TAPS = 16'hB400
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= SEED;
    else if (step_i) q <= q[0] ? ((q >> 1) ^ TAPS) : (q >> 1);
  end

  assign state_o = q;

  AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q != '0); // R8
endmodule

// File: rtl/vr_way_classify.sv
module vr_way_classify #(
  parameter int unsigned N     = 16,
  parameter int unsigned TAG_W = 20
) (
  input  logic [N-1:0]       vld_i,
  input  logic [N-1:0]       rpl_i,
  input  logic [N-1:0]       shr_i,
  input  logic [N*TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]   tag_i,
  output logic [N-1:0]       match_o,
  output logic [N-1:0]       inv_o,
  output logic [N-1:0]       free_o,
  output logic [N-1:0]       rep_o
);
  for (genvar i = 0; i < N; i++) begin : g_way
    assign inv_o[i]   = ~vld_i[i];
    assign free_o[i]  = vld_i[i] & ~rpl_i[i] & ~shr_i[i];
    assign rep_o[i]   = vld_i[i] &  rpl_i[i];
    assign match_o[i] = vld_i[i] &  rpl_i[i] & (tags_i[i*TAG_W +: TAG_W] == tag_i);
  end
endmodule

// File: rtl/vr_rot_pick.sv
module vr_rot_pick #(
  parameter int unsigned N     = 16,
  parameter int unsigned WAY_W = $clog2(N)
) (
  input  logic [N-1:0]     mask_i,
  input  logic [WAY_W-1:0] start_i,
  output logic             hit_o,
  output logic [WAY_W-1:0] way_o
);
  always_comb begin
    hit_o = 1'b0;
    way_o = '0;
    for (int i = 0; i < N; i++) begin
      logic [WAY_W-1:0] p;
      p = start_i + WAY_W'(i);
      if (!hit_o && mask_i[p]) begin
        hit_o = 1'b1;
        way_o = p;
      end
    end
  end
endmodule

// File: rtl/vr_way_select.sv
module vr_way_select
  import vr_pkg::*;
#(
  parameter int unsigned NUM_WAYS = 16,
  parameter int unsigned SET_W    = 10,
  parameter int unsigned TAG_W    = 20,
  parameter int unsigned LFSR_W   = 16,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic [SET_W-1:0]          req_set_i,
  input  logic [TAG_W-1:0]          req_tag_i,
  input  logic [NUM_WAYS-1:0]       way_valid_i,
  input  logic [NUM_WAYS-1:0]       way_repl_i,
  input  logic [NUM_WAYS-1:0]       way_shrd_i,
  input  logic [NUM_WAYS*TAG_W-1:0] way_tags_i,
  output logic                      rsp_valid_o,
  input  logic                      rsp_ready_i,
  output logic                      rsp_replicated_o,
  output logic [WAY_W-1:0]          rsp_way_o,
  output logic                      rsp_evict_home_o,
  output logic                      wr_en_o,
  output logic [SET_W-1:0]          wr_set_o,
  output logic [TAG_W-1:0]          wr_tag_o
);
  logic                      busy_q;
  logic [SET_W-1:0]          set_q;
  logic [TAG_W-1:0]          tag_q;
  logic [NUM_WAYS-1:0]       vld_q, rpl_q, shr_q;
  logic [NUM_WAYS*TAG_W-1:0] tags_q;
  logic [WAY_W-1:0]          start_q;
  logic [LFSR_W-1:0]         lfsr;

  logic accept, fire;
  assign accept = req_valid_i & ~busy_q;
  assign fire   = busy_q & rsp_ready_i;

  vr_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED), .TAPS(LFSR_TAPS)) u_lfsr (
    .clk_i, .rst_ni, .step_i(accept), .state_o(lfsr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      set_q   <= '0;
      tag_q   <= '0;
      vld_q   <= '0;
      rpl_q   <= '0;
      shr_q   <= '0;
      tags_q  <= '0;
      start_q <= '0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      set_q   <= req_set_i;
      tag_q   <= req_tag_i;
      vld_q   <= way_valid_i;
      rpl_q   <= way_repl_i;
      shr_q   <= way_shrd_i;
      tags_q  <= way_tags_i;
      start_q <= lfsr[WAY_W-1:0];
    end else if (fire) begin
      busy_q  <= 1'b0;
    end
  end

  // class masks, order: match, invalid, free home, replica
  logic [NUM_CLS-1:0][NUM_WAYS-1:0] cls_mask;
  logic [NUM_CLS-1:0]               cls_hit;
  logic [NUM_CLS-1:0][WAY_W-1:0]    cls_way;

  vr_way_classify #(.N(NUM_WAYS), .TAG_W(TAG_W)) u_cls (
    .vld_i(vld_q), .rpl_i(rpl_q), .shr_i(shr_q), .tags_i(tags_q), .tag_i(tag_q),
    .match_o(cls_mask[0]), .inv_o(cls_mask[1]), .free_o(cls_mask[2]), .rep_o(cls_mask[3])
  );

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_pick
    logic [WAY_W-1:0] st;
    if (g == 0) begin : g_fixed
      assign st = '0;  // lowest matching replica
    end else begin : g_rot
      assign st = start_q;
    end
    vr_rot_pick #(.N(NUM_WAYS), .WAY_W(WAY_W)) u_pick (
      .mask_i(cls_mask[g]), .start_i(st), .hit_o(cls_hit[g]), .way_o(cls_way[g])
    );
  end

  vr_cls_e          sel_cls;
  logic [WAY_W-1:0] sel_way;

  always_comb begin
    sel_cls = CLS_NONE;
    sel_way = '0;
    if      (cls_hit[0]) begin sel_cls = CLS_MATCH; sel_way = cls_way[0]; end
    else if (cls_hit[1]) begin sel_cls = CLS_INV;   sel_way = cls_way[1]; end
    else if (cls_hit[2]) begin sel_cls = CLS_FREE;  sel_way = cls_way[2]; end
    else if (cls_hit[3]) begin sel_cls = CLS_REP;   sel_way = cls_way[3]; end
  end

  assign req_ready_o      = ~busy_q;
  assign rsp_valid_o      = busy_q;
  assign rsp_replicated_o = busy_q & (sel_cls != CLS_NONE);
  assign rsp_way_o        = busy_q ? sel_way : '0;
  assign rsp_evict_home_o = busy_q & (sel_cls == CLS_FREE);
  assign wr_en_o          = fire & (sel_cls != CLS_NONE);
  assign wr_set_o         = set_q;
  assign wr_tag_o         = tag_q;

  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_way_o)
      && $stable(rsp_replicated_o) && $stable(rsp_evict_home_o)); // R2
  AST_READY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o); // R2
  AST_MATCH_REUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && |cls_mask[0] |-> rpl_q[rsp_way_o] && !rsp_evict_home_o); // R3
  AST_INV_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !(|cls_mask[0]) && !(&vld_q) |-> !vld_q[rsp_way_o]); // R4
  AST_EVICT_HOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_evict_home_o |-> rsp_replicated_o && !rpl_q[rsp_way_o] && !shr_q[rsp_way_o]); // R5
  AST_NO_SHARED_VICTIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_replicated_o |-> !(vld_q[rsp_way_o] && !rpl_q[rsp_way_o] && shr_q[rsp_way_o])); // R7
  AST_ALL_SHARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && (&(vld_q & ~rpl_q & shr_q)) |-> !rsp_replicated_o && !wr_en_o); // R7
  AST_WR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o && !rsp_valid_o); // R9
endmodule

// File: tb/vr_way_select_tb.sv
module vr_way_select_tb;
  localparam int N = 16, SET_W = 10, TAG_W = 20;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, rsp_ready_i = 1'b0;
  logic [SET_W-1:0] req_set_i = '0;
  logic [TAG_W-1:0] req_tag_i = '0;
  logic [N-1:0] way_valid_i = '0, way_repl_i = '0, way_shrd_i = '0;
  logic [N*TAG_W-1:0] way_tags_i = '0;
  logic req_ready_o, rsp_valid_o, rsp_replicated_o, rsp_evict_home_o, wr_en_o;
  logic [3:0] rsp_way_o;
  logic [SET_W-1:0] wr_set_o;
  logic [TAG_W-1:0] wr_tag_o;

  always #5 clk = ~clk;

  vr_way_select u_dut (.clk_i(clk), .rst_ni, .req_valid_i, .req_ready_o, .req_set_i,
    .req_tag_i, .way_valid_i, .way_repl_i, .way_shrd_i, .way_tags_i, .rsp_valid_o,
    .rsp_ready_i, .rsp_replicated_o, .rsp_way_o, .rsp_evict_home_o, .wr_en_o,
    .wr_set_o, .wr_tag_o);

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_lfsr = 16'hACE1;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int pick(input logic [15:0] m, input int st);
    for (int i = 0; i < 16; i++) if (m[(st + i) % 16]) return (st + i) % 16;
    return -1;
  endfunction

  function automatic logic [N*TAG_W-1:0] std_tags();
    logic [N*TAG_W-1:0] t;
    for (int i = 0; i < N; i++) t[i*TAG_W +: TAG_W] = TAG_W'(32'h100 + i);
    return t;
  endfunction

  // {valid, repl, shrd, class}: class 0 none, 1 invalid, 2 free home, 3 replica, 4 match
  localparam logic [50:0] VEC [10] = '{
    {16'h0000, 16'h0000, 16'h0000, 3'd1},
    {16'hFDFF, 16'h0000, 16'hFFFF, 3'd1},
    {16'hFFFF, 16'h0000, 16'h0000, 3'd2},
    {16'hFFFF, 16'hEFF7, 16'h0000, 3'd2},
    {16'hFFFF, 16'h00F0, 16'hFF0F, 3'd3},
    {16'hFFFF, 16'h0000, 16'hFFFF, 3'd0},
    {16'h7FFF, 16'h000F, 16'h0000, 3'd1},
    {16'hFFFF, 16'hFFFF, 16'h0000, 3'd3},
    {16'hFFFF, 16'h0000, 16'h0000, 3'd2},
    {16'hFFFF, 16'h0001, 16'hFFFE, 3'd3}
  };

  task automatic run_req(input logic [15:0] v, input logic [15:0] r, input logic [15:0] s,
                         input logic [TAG_W-1:0] tg, input logic [SET_W-1:0] st_idx,
                         input int cls, input string rq);
    int st, exp_way;
    bit exp_rep, exp_ev;
    @(negedge clk);
    way_valid_i = v; way_repl_i = r; way_shrd_i = s; way_tags_i = std_tags();
    req_tag_i = tg; req_set_i = st_idx; req_valid_i = 1'b1;
    check(req_ready_o == 1'b1, "R2 ready idle", int'(req_ready_o), 1);
    @(posedge clk);
    st = int'(m_lfsr[3:0]);
    m_lfsr = m_lfsr[0] ? ((m_lfsr >> 1) ^ 16'hB400) : (m_lfsr >> 1);
    case (cls)
      1: exp_way = pick(~v, st);
      2: exp_way = pick(v & ~r & ~s, st);
      3: exp_way = pick(v & r, st);
      4: exp_way = pick(16'(1 << (tg - 20'h100)), 0);
      default: exp_way = 0;
    endcase
    exp_rep = (cls != 0);
    exp_ev  = (cls == 2);
    @(negedge clk);
    req_valid_i = 1'b0;
    for (int k = 0; k < 2; k++) begin
      check(rsp_valid_o == 1'b1, "R2 rsp valid", int'(rsp_valid_o), 1);
      check(req_ready_o == 1'b0, "R2 ready low busy", int'(req_ready_o), 0);
      check(rsp_replicated_o == exp_rep, {rq, " replicated"}, int'(rsp_replicated_o), int'(exp_rep));
      check(int'(rsp_way_o) == exp_way, {rq, " way"}, int'(rsp_way_o), exp_way);
      check(rsp_evict_home_o == exp_ev, {rq, " evict_home"}, int'(rsp_evict_home_o), int'(exp_ev));
      check(wr_en_o == 1'b0, "R9 no write while held", int'(wr_en_o), 0);
      if (k == 0) begin
        // R10: scramble inputs while in flight
        way_valid_i = ~v; way_repl_i = ~r; way_shrd_i = 16'h0; way_tags_i = '0;
        req_tag_i = ~tg; req_set_i = ~st_idx;
        @(negedge clk);
      end
    end
    rsp_ready_i = 1'b1;
    #1;
    check(wr_en_o == exp_rep, "R9 write pulse", int'(wr_en_o), int'(exp_rep));
    if (exp_rep) begin
      check(wr_set_o == st_idx, "R9 R10 write set", int'(wr_set_o), int'(st_idx));
      check(wr_tag_o == tg, "R9 R10 write tag", int'(wr_tag_o), int'(tg));
    end
    @(negedge clk);
    rsp_ready_i = 1'b0;
    check(rsp_valid_o == 1'b0, "R2 rsp drop", int'(rsp_valid_o), 0);
    check(req_ready_o == 1'b1, "R2 ready back", int'(req_ready_o), 1);
    check(wr_en_o == 1'b0, "R9 single pulse", int'(wr_en_o), 0);
  endtask

  bit done = 1'b0;

  initial begin
    #1;
    check(req_ready_o == 1'b1, "R1 ready", int'(req_ready_o), 1);
    check(rsp_valid_o == 1'b0, "R1 rsp_valid", int'(rsp_valid_o), 0);
    check(wr_en_o == 1'b0, "R1 wr_en", int'(wr_en_o), 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < 10; i++) begin
      string rq;
      case (int'(VEC[i][2:0]))
        0: rq = "R7";
        1: rq = "R4 R8";
        2: rq = "R5 R8";
        default: rq = "R6 R8";
      endcase
      run_req(VEC[i][50:35], VEC[i][34:19], VEC[i][18:3], 20'h00ABC, SET_W'(i * 37),
              int'(VEC[i][2:0]), rq);
    end
    // repeat the all-free case: start point follows the LFSR sequence
    for (int i = 0; i < 6; i++)
      run_req(16'hFFFF, 16'h0000, 16'h0000, 20'h00ABC, 10'h155, 2, "R8 rotation");
    // reuse of a matching replica beats all other classes
    run_req(16'hFFFF, 16'hFFFF, 16'h0000, 20'h00106, 10'h3A0, 4, "R3 reuse");
    run_req(16'h7FFF, 16'h0040, 16'h0000, 20'h00106, 10'h021, 4, "R3 beats invalid");
    run_req(16'hFFFF, 16'h2000, 16'hDFFF, 20'h0010D, 10'h0F0, 4, "R3 among shared");
    // same tag on a non-replica home line: no reuse, falls to free home
    run_req(16'hFFFF, 16'h0000, 16'hFFBF, 20'h00106, 10'h011, 2, "R3 R5 home tag");
    // mid-stream reset returns to idle and reseeds
    @(negedge clk);
    req_valid_i = 1'b1; way_valid_i = 16'hFFFF;
    @(negedge clk);
    req_valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    check(rsp_valid_o == 1'b0, "R1 reset in flight", int'(rsp_valid_o), 0);
    check(req_ready_o == 1'b1, "R1 ready after reset", int'(req_ready_o), 1);
    @(negedge clk);
    rst_ni = 1'b1;
    m_lfsr = 16'hACE1;
    run_req(16'hFFFF, 16'h0000, 16'h0000, 20'h00ABC, 10'h2AA, 2, "R1 R8 reseed");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule